// File: doc/BRIEF.md
# Condition Register Execution Unit

This block is the combinational execute stage for a 32-bit condition register that is organised as eight 4-bit fields. Each cycle it takes an operation code, bit and field selectors, an 8-bit field mask, a 4-bit truth table, two 64-bit register operands and the current condition register value. It returns the next condition register value with a write enable, and a 64-bit register result with its own write enable. Instruction decode, register files and pipeline registers belong to the surrounding core.

Bit-combining operations are not decoded one by one. The instruction carries a 4-bit truth table, and the two selected source bits index into it. Moves into the register come in two forms. The multi-field form writes every field whose mask bit is set. The single-field form writes exactly one field, which is picked by the most significant set mask bit.

The numbering is the same throughout. Selector value k addresses `cr[31-k]`, so bit 0 is the most significant bit. Field n occupies `cr[31-4n:28-4n]`. Mask bit `7-n` belongs to field n, so mask bit 7 governs `cr[31:28]`.

Top module: `cr_exec_unit`

## Requirements
- R1: With op 0 (bit logic), with a = `cr_i[31-sel_a_i]` and b = `cr_i[31-sel_b_i]`, `cr_o[31-sel_t_i]` equals `tt_i[{a,b}]`, with a as the most significant index bit. All other bits equal `cr_i`, `cr_we_o`=1 and `res_we_o`=0.
- R2: With op 1 (field copy), field `fld_dst_i` of `cr_o` takes field `fld_src_i` of `cr_i`, all other fields are unchanged, and `cr_we_o`=1.
- R3: With op 2 (multi-field move in), each mask bit is widened to 4 bits, so 0xF1 becomes 0xFFFF000F. `cr_o` takes `opa_i[31:0]` where that mask is 1 and `cr_i` where it is 0, and `cr_we_o`=1.
- R4: With op 3 (single-field move in) and a mask that has exactly one bit set, only the selected field is copied from `opa_i[31:0]`. The other 28 bits are unchanged.
- R5: With op 3 and a mask that has several bits set, only the field of the most significant set mask bit is copied. A zero mask leaves `cr_o` equal to `cr_i`.
- R6: With op 4 (full move out), `res_o` is `{32'b0, cr_i}`, `res_we_o`=1 and `cr_we_o`=0.
- R7: With op 5 (single-field move out), `res_o` holds the field picked as in R5 at its own bit position and zeros everywhere else. A zero mask gives zero. `res_we_o`=1.
- R8: With op 6 (select), `res_o` is `opa_i` when `cr_i[31-sel_a_i]` is 1 and `opb_i` when it is 0, and `res_we_o`=1.
- R9: With op 7 (idle), both write enables are 0. Whenever `cr_we_o` is 0, `cr_o` equals `cr_i`. Whenever `res_we_o` is 0, `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code, 0 to 7 as in the requirements |
| sel_a_i | input | 5 | First source bit selector; also the condition bit for select |
| sel_b_i | input | 5 | Second source bit selector |
| sel_t_i | input | 5 | Target bit selector |
| tt_i | input | 4 | Truth table for bit logic |
| fld_src_i | input | 3 | Source field index for field copy |
| fld_dst_i | input | 3 | Target field index for field copy |
| fmask_i | input | 8 | Field mask, bit 7-n for field n |
| opa_i | input | 64 | First register operand |
| opb_i | input | 64 | Second register operand |
| cr_i | input | 32 | Current condition register |
| cr_o | output | 32 | Next condition register |
| cr_we_o | output | 1 | Condition register write enable |
| res_o | output | 64 | Register result |
| res_we_o | output | 1 | Register result write enable |

## Verification
The hardest case to reach from the ports is a single-field move whose mask has several bits set. Random masks seldom cover the specific patterns that separate "highest set bit wins" from other plausible rules, such as lowest bit, merging all fields, or no change. The stimulus therefore applies these masks directly against condition register and operand values whose fields all differ: a contiguous low-half mask, a mask with its top bit and a low bit set, and an all-zero mask. Any wrong field choice then changes a visible nibble. A long random phase follows, which covers every operation with all selector and truth-table values.

// File: rtl/cr_exec_pkg.sv
package cr_exec_pkg;

   typedef enum logic [2:0] {
      CR_OP_LOGIC    = 3'd0,
      CR_OP_FCOPY    = 3'd1,
      CR_OP_MTMULTI  = 3'd2,
      CR_OP_MTSINGLE = 3'd3,
      CR_OP_MFALL    = 3'd4,
      CR_OP_MFSINGLE = 3'd5,
      CR_OP_SELECT   = 3'd6,
      CR_OP_IDLE     = 3'd7
   } cr_op_e;

   localparam int CR_OP_W = 3;

endpackage

// File: rtl/cr_mask_expand.sv
module cr_mask_expand #(
   parameter int NF = 8,
   parameter int FW = 4
) (
   input  logic [NF-1:0]    fmask_i,
   output logic [NF*FW-1:0] bitmask_o
);

   for (genvar g = 0; g < NF; g++) begin : g_slot
      assign bitmask_o[g*FW +: FW] = {FW{fmask_i[g]}};
   end

endmodule

// File: rtl/cr_msb_picker.sv
module cr_msb_picker #(
   parameter int W = 8
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] grant_o
);

   if (W < 1) begin : g_bad
      $error("cr_msb_picker: W must be at least 1");
   end

   for (genvar g = 0; g < W; g++) begin : g_pick
      if (g == W-1) begin : g_top
         assign grant_o[g] = req_i[g];
      end else begin : g_rest
         assign grant_o[g] = req_i[g] & ~(|req_i[W-1:g+1]);
      end
   end

endmodule

// File: rtl/cr_bit_logic.sv
module cr_bit_logic #(
   parameter int CRW  = 32,
   parameter int SELW = $clog2(CRW)
) (
   input  logic [CRW-1:0]  cr_i,
   input  logic [SELW-1:0] sel_a_i,
   input  logic [SELW-1:0] sel_b_i,
   input  logic [SELW-1:0] sel_t_i,
   input  logic [3:0]      tt_i,
   output logic [CRW-1:0]  cr_o
);

   localparam logic [SELW-1:0] TOP = SELW'(CRW-1);

   logic [SELW-1:0] pos_a, pos_b, pos_t;
   logic [1:0]      tt_idx;

   assign pos_a  = TOP - sel_a_i;
   assign pos_b  = TOP - sel_b_i;
   assign pos_t  = TOP - sel_t_i;
   assign tt_idx = {cr_i[pos_a], cr_i[pos_b]};

   always_comb begin
      cr_o        = cr_i;
      cr_o[pos_t] = tt_i[tt_idx];
   end

endmodule

// File: rtl/cr_field_copy.sv
module cr_field_copy #(
   parameter int NF  = 8,
   parameter int FW  = 4,
   parameter int FIW = $clog2(NF)
) (
   input  logic [NF*FW-1:0] cr_i,
   input  logic [FIW-1:0]   src_i,
   input  logic [FIW-1:0]   dst_i,
   output logic [NF*FW-1:0] cr_o
);

   logic [FW-1:0] picked;

   always_comb begin
      picked = '0;
      for (int n = 0; n < NF; n++) begin
         if (src_i == FIW'(n)) picked = cr_i[(NF-1-n)*FW +: FW];
      end
   end

   for (genvar n = 0; n < NF; n++) begin : g_fld
      assign cr_o[(NF-1-n)*FW +: FW] =
         (dst_i == FIW'(n)) ? picked : cr_i[(NF-1-n)*FW +: FW];
   end

endmodule

// File: rtl/cr_exec_unit.sv
module cr_exec_unit #(
   parameter int NF    = 8,
   parameter int FW    = 4,
   parameter int REG_W = 64,
   localparam int CRW  = NF*FW,
   localparam int SELW = $clog2(CRW),
   localparam int FIW  = $clog2(NF)
) (
   input  logic [2:0]       op_i,
   input  logic [SELW-1:0]  sel_a_i,
   input  logic [SELW-1:0]  sel_b_i,
   input  logic [SELW-1:0]  sel_t_i,
   input  logic [3:0]       tt_i,
   input  logic [FIW-1:0]   fld_src_i,
   input  logic [FIW-1:0]   fld_dst_i,
   input  logic [NF-1:0]    fmask_i,
   input  logic [REG_W-1:0] opa_i,
   input  logic [REG_W-1:0] opb_i,
   input  logic [CRW-1:0]   cr_i,
   output logic [CRW-1:0]   cr_o,
   output logic             cr_we_o,
   output logic [REG_W-1:0] res_o,
   output logic             res_we_o
);
   import cr_exec_pkg::*;

   if (REG_W < CRW) begin : g_chk_w
      $error("cr_exec_unit: REG_W must hold the whole condition register");
   end
   if (NF < 2 || FW < 1) begin : g_chk_nf
      $error("cr_exec_unit: need at least two fields of one bit");
   end
   if ((1 << SELW) != CRW) begin : g_chk_pow
      $error("cr_exec_unit: register width must be a power of two");
   end

   localparam logic [SELW-1:0] TOP = SELW'(CRW-1);

   cr_op_e          op;
   logic [CRW-1:0]  cr_logic, cr_copy, multi_mask, single_mask;
   logic [NF-1:0]   picked_mask;
   logic [CRW-1:0]  src_low;
   logic            cond_bit;

   assign op      = cr_op_e'(op_i);
   assign src_low = opa_i[CRW-1:0];

   cr_bit_logic #(.CRW(CRW), .SELW(SELW)) u_logic (
      .cr_i   (cr_i),
      .sel_a_i(sel_a_i),
      .sel_b_i(sel_b_i),
      .sel_t_i(sel_t_i),
      .tt_i   (tt_i),
      .cr_o   (cr_logic)
   );

   cr_field_copy #(.NF(NF), .FW(FW), .FIW(FIW)) u_copy (
      .cr_i (cr_i),
      .src_i(fld_src_i),
      .dst_i(fld_dst_i),
      .cr_o (cr_copy)
   );

   cr_msb_picker #(.W(NF)) u_pick (
      .req_i  (fmask_i),
      .grant_o(picked_mask)
   );

   cr_mask_expand #(.NF(NF), .FW(FW)) u_exp_multi (
      .fmask_i  (fmask_i),
      .bitmask_o(multi_mask)
   );

   cr_mask_expand #(.NF(NF), .FW(FW)) u_exp_single (
      .fmask_i  (picked_mask),
      .bitmask_o(single_mask)
   );

   assign cond_bit = cr_i[TOP - sel_a_i];

   always_comb begin
      cr_o     = cr_i;
      cr_we_o  = 1'b0;
      res_o    = '0;
      res_we_o = 1'b0;
      unique case (op)
         CR_OP_LOGIC: begin
            cr_o    = cr_logic;
            cr_we_o = 1'b1;
         end
         CR_OP_FCOPY: begin
            cr_o    = cr_copy;
            cr_we_o = 1'b1;
         end
         CR_OP_MTMULTI: begin
            cr_o    = (src_low & multi_mask) | (cr_i & ~multi_mask);
            cr_we_o = 1'b1;
         end
         CR_OP_MTSINGLE: begin
            cr_o    = (src_low & single_mask) | (cr_i & ~single_mask);
            cr_we_o = 1'b1;
         end
         CR_OP_MFALL: begin
            res_o    = REG_W'(cr_i);
            res_we_o = 1'b1;
         end
         CR_OP_MFSINGLE: begin
            res_o    = REG_W'(cr_i & single_mask);
            res_we_o = 1'b1;
         end
         CR_OP_SELECT: begin
            res_o    = cond_bit ? opa_i : opb_i;
            res_we_o = 1'b1;
         end
         default: begin
            cr_we_o  = 1'b0;
            res_we_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cr_exec_unit_chk.sv
module cr_exec_unit_chk #(
   parameter int NF    = 8,
   parameter int FW    = 4,
   parameter int REG_W = 64,
   localparam int CRW  = NF*FW,
   localparam int SELW = $clog2(CRW),
   localparam int FIW  = $clog2(NF)
) (
   input logic [2:0]       op_i,
   input logic [FIW-1:0]   fld_dst_i,
   input logic [NF-1:0]    fmask_i,
   input logic [REG_W-1:0] opa_i,
   input logic [REG_W-1:0] opb_i,
   input logic [CRW-1:0]   cr_i,
   input logic [CRW-1:0]   cr_o,
   input logic             cr_we_o,
   input logic [REG_W-1:0] res_o,
   input logic             res_we_o
);

   logic [CRW-1:0] diff, dst_span, mask_span, hot_span;

   always_comb begin
      diff      = cr_o ^ cr_i;
      dst_span  = '0;
      mask_span = '0;
      hot_span  = '0;
      for (int n = 0; n < NF; n++) begin
         if (fld_dst_i == FIW'(n)) dst_span[(NF-1-n)*FW +: FW] = '1;
         if (fmask_i[NF-1-n]) mask_span[(NF-1-n)*FW +: FW] = '1;
      end
      if ($countones(fmask_i) == 1) hot_span = mask_span;
   end

   always_comb begin
      // R1
      crl_single_bit_chk: assert (op_i != 3'd0 ||
         ($countones(diff) <= 1 && cr_we_o && !res_we_o))
         else $error("bit logic touched more than one bit");
      // R2
      fcopy_one_field_chk: assert (op_i != 3'd1 || (diff & ~dst_span) == '0)
         else $error("field copy changed another field");
      // R3
      mmove_keep_chk: assert (op_i != 3'd2 || (diff & ~mask_span) == '0)
         else $error("multi move changed an unmasked field");
      // R4
      smove_onehot_chk: assert (op_i != 3'd3 || $countones(fmask_i) != 1 ||
         (diff & ~hot_span) == '0)
         else $error("single move changed an unselected field");
      // R6
      mfall_upper_zero_chk: assert (op_i != 3'd4 ||
         (res_o[REG_W-1:CRW] == '0 && res_o[CRW-1:0] == cr_i && !cr_we_o))
         else $error("full move out wrong");
      // R7
      mfsingle_zero_chk: assert (op_i != 3'd5 ||
         (res_o[REG_W-1:CRW] == '0 && (res_o[CRW-1:0] & ~cr_i) == '0 &&
          $countones(res_o[CRW-1:0] & ~mask_span) == 0))
         else $error("single move out leaked bits");
      // R8
      select_operand_chk: assert (op_i != 3'd6 ||
         (res_we_o && (res_o == opa_i || res_o == opb_i)))
         else $error("select result is neither operand");
      // R9
      idle_quiet_chk: assert ((cr_we_o || cr_o == cr_i) &&
         (res_we_o || res_o == '0) && (op_i != 3'd7 || (!cr_we_o && !res_we_o)))
         else $error("outputs active without write enable");
   end

endmodule

bind cr_exec_unit cr_exec_unit_chk #(.NF(NF), .FW(FW), .REG_W(REG_W)) u_chk (
   .op_i     (op_i),
   .fld_dst_i(fld_dst_i),
   .fmask_i  (fmask_i),
   .opa_i    (opa_i),
   .opb_i    (opb_i),
   .cr_i     (cr_i),
   .cr_o     (cr_o),
   .cr_we_o  (cr_we_o),
   .res_o    (res_o),
   .res_we_o (res_we_o)
);

// File: tb/cr_exec_unit_bench.sv
module cr_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op;
   logic [4:0]  sel_a, sel_b, sel_t;
   logic [3:0]  tt;
   logic [2:0]  fsrc, fdst;
   logic [7:0]  fmask;
   logic [63:0] opa, opb;
   logic [31:0] cr_in;
   logic [31:0] cr_out;
   logic        cr_we;
   logic [63:0] res;
   logic        res_we;

   int checks = 0;
   int failures = 0;
   bit running = 1'b0;
   bit done = 1'b0;
   string tag = "R9";

   always #10 clk = ~clk;

   cr_exec_unit u_cr_exec_unit (
      .op_i(op), .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_t_i(sel_t),
      .tt_i(tt), .fld_src_i(fsrc), .fld_dst_i(fdst), .fmask_i(fmask),
      .opa_i(opa), .opb_i(opb), .cr_i(cr_in),
      .cr_o(cr_out), .cr_we_o(cr_we), .res_o(res), .res_we_o(res_we)
   );

   function automatic int top_field(input logic [7:0] m);
      for (int f = 0; f < 8; f++) if (m[7-f]) return f;
      return -1;
   endfunction

   task automatic model(output logic [31:0] e_cr, output bit e_crwe,
                        output logic [63:0] e_res, output bit e_reswe);
      int f;
      e_cr = cr_in; e_crwe = 0; e_res = '0; e_reswe = 0;
      case (op)
         3'd0: begin
            e_cr[31-sel_t] = tt[2*int'(cr_in[31-sel_a]) + int'(cr_in[31-sel_b])];
            e_crwe = 1;
         end
         3'd1: begin
            for (int k = 0; k < 4; k++) e_cr[31-4*fdst-k] = cr_in[31-4*fsrc-k];
            e_crwe = 1;
         end
         3'd2: begin
            for (int i = 0; i < 32; i++)
               if (fmask[7-(31-i)/4]) e_cr[i] = opa[i];
            e_crwe = 1;
         end
         3'd3: begin
            f = top_field(fmask);
            if (f >= 0) for (int k = 0; k < 4; k++) e_cr[31-4*f-k] = opa[31-4*f-k];
            e_crwe = 1;
         end
         3'd4: begin e_res = {32'h0, cr_in}; e_reswe = 1; end
         3'd5: begin
            f = top_field(fmask);
            if (f >= 0) for (int k = 0; k < 4; k++) e_res[31-4*f-k] = cr_in[31-4*f-k];
            e_reswe = 1;
         end
         3'd6: begin e_res = cr_in[31-sel_a] ? opa : opb; e_reswe = 1; end
         default: ;
      endcase
   endtask

   function automatic string op_tag(input logic [2:0] o);
      case (o)
         3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
         3'd3: return "R4"; 3'd4: return "R6"; 3'd5: return "R7";
         3'd6: return "R8"; default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] e_cr; bit e_crwe; logic [63:0] e_res; bit e_reswe;
      if (running) begin
         model(e_cr, e_crwe, e_res, e_reswe);
         checks++;
         if (cr_out !== e_cr || cr_we !== e_crwe || res !== e_res || res_we !== e_reswe) begin
            failures++;
            $display("FAIL %s op=%0d act cr=%h we=%b res=%h rwe=%b exp cr=%h we=%b res=%h rwe=%b",
                     tag, op, cr_out, cr_we, res, res_we, e_cr, e_crwe, e_res, e_reswe);
         end
      end
   end

   task automatic drive(input string t, input logic [2:0] o, input logic [4:0] a,
                        input logic [4:0] b, input logic [4:0] tg, input logic [3:0] tab,
                        input logic [2:0] s, input logic [2:0] d, input logic [7:0] m,
                        input logic [63:0] x, input logic [63:0] y, input logic [31:0] c);
      @(negedge clk);
      tag = t; op = o; sel_a = a; sel_b = b; sel_t = tg; tt = tab;
      fsrc = s; fdst = d; fmask = m; opa = x; opb = y; cr_in = c;
   endtask

   task automatic const_check(input string t, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic finish_up;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   localparam logic [63:0] OPA = 64'hCAFE0000_12345678;
   localparam logic [63:0] OPB = 64'h0BAD0000_9ABCDEF0;
   localparam logic [31:0] CRV = 32'hDEADBEEF;

   initial begin
      op = 3'd7; sel_a = '0; sel_b = '0; sel_t = '0; tt = '0;
      fsrc = '0; fdst = '0; fmask = '0; opa = OPA; opb = OPB; cr_in = CRV;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // R9 idle state after reset: nothing written
      const_check("R9", {cr_out, 30'd0, cr_we, res_we}, {CRV, 32'd0});
      const_check("R9", res, 64'd0);
      running = 1'b1;
      // R1 every truth-table index with AND (index 3 only)
      for (int i = 0; i < 4; i++) begin
         drive("R1", 3'd0, 5'd0, 5'd1, 5'd31, 4'b1000, 0, 0, 0, OPA, OPB,
               {i[1], i[0], 30'h0});
      end
      drive("R1", 3'd0, 5'd3, 5'd3, 5'd4, 4'b0110, 0, 0, 0, OPA, OPB, CRV);
      // R2
      drive("R2", 3'd1, 0, 0, 0, 0, 3'd7, 3'd0, 0, OPA, OPB, 32'h01234567);
      @(negedge clk); const_check("R2", {32'd0, cr_out}, 64'h71234567);
      // R3 documented example mask 0xF1
      drive("R3", 3'd2, 0, 0, 0, 0, 0, 0, 8'hF1, OPA, OPB, CRV);
      @(negedge clk); const_check("R3", {32'd0, cr_out}, 64'h1234BEE8);
      // R4 one-hot mask
      drive("R4", 3'd3, 0, 0, 0, 0, 0, 0, 8'h20, OPA, OPB, CRV);
      @(negedge clk); const_check("R4", {32'd0, cr_out}, 64'hDE3DBEEF);
      // R5 non-one-hot masks and zero mask
      drive("R5", 3'd3, 0, 0, 0, 0, 0, 0, 8'h0F, OPA, OPB, CRV);
      @(negedge clk); const_check("R5", {32'd0, cr_out}, 64'hDEAD5EEF);
      drive("R5", 3'd3, 0, 0, 0, 0, 0, 0, 8'h81, OPA, OPB, CRV);
      @(negedge clk); const_check("R5", {32'd0, cr_out}, 64'h1EADBEEF);
      drive("R5", 3'd3, 0, 0, 0, 0, 0, 0, 8'h00, OPA, OPB, CRV);
      @(negedge clk); const_check("R5", {31'd0, cr_we, cr_out}, {31'd0, 1'b1, CRV});
      // R6
      drive("R6", 3'd4, 0, 0, 0, 0, 0, 0, 0, OPA, OPB, CRV);
      @(negedge clk); const_check("R6", res, {32'd0, CRV});
      // R7 single field out, non-one-hot and zero mask
      drive("R7", 3'd5, 0, 0, 0, 0, 0, 0, 8'h06, OPA, OPB, CRV);
      @(negedge clk); const_check("R7", res, 64'h00000000_00000E00);
      drive("R7", 3'd5, 0, 0, 0, 0, 0, 0, 8'h00, OPA, OPB, CRV);
      @(negedge clk); const_check("R7", res, 64'd0);
      // R8 both outcomes
      drive("R8", 3'd6, 5'd0, 0, 0, 0, 0, 0, 0, OPA, OPB, CRV);
      @(negedge clk); const_check("R8", res, OPA);
      drive("R8", 3'd6, 5'd2, 0, 0, 0, 0, 0, 0, OPA, OPB, CRV);
      @(negedge clk); const_check("R8", res, OPB);
      // R9 idle with busy inputs
      drive("R9", 3'd7, 5'd9, 5'd9, 5'd9, 4'hF, 3'd1, 3'd2, 8'hFF, OPA, OPB, CRV);
      // random phase, all operations
      for (int n = 0; n < 2000; n++) begin
         logic [2:0] ro;
         ro = 3'($urandom);
         drive(op_tag(ro), ro, 5'($urandom), 5'($urandom), 5'($urandom),
               4'($urandom), 3'($urandom), 3'($urandom), 8'($urandom),
               {$urandom, $urandom}, {$urandom, $urandom}, $urandom);
      end
      @(negedge clk);
      running = 1'b0;
      done = 1'b1;
      finish_up();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=hung exp=finished");
         finish_up();
      end
   end

endmodule